// File: doc/BRIEF.md
# Banked Output-Enable Pad Control

This block decides, for each of twelve I/O pins of one logic block, whether the pin's output driver is switched on, and it returns the value seen on each pad to the routing. The pins form two banks of six. Each bank receives two shared enable terms from the logic array. A 2-bit mode per pin selects how that pin's enable is formed: held off, held on, or taken from one of the two terms of the pin's own bank.

The pad is modelled as a separate pair, a drive enable and a drive value, plus a pad input that carries what the outside world drives. The feedback to the routing is the driven value when the pin drives and the external pad value when it does not. With these modes a pin can act as an output, an input, a bidirectional pin, or a three-state driver on a shared bus. The path from the enable terms to the drive enables is purely combinational.

Top module: `io_bank_oe_ctrl`

## Requirements
- R1: A pin whose mode field is 2'b00 has its drive enable low whatever the enable terms are.
- R2: A pin whose mode field is 2'b01 has its drive enable high whatever the enable terms are.
- R3: A pin whose mode field is 2'b10 has its drive enable equal to term A of its own bank.
- R4: A pin whose mode field is 2'b11 has its drive enable equal to term B of its own bank.
- R5: Pins 0 to 5 belong to bank 0 (term bit 0) and pins 6 to 11 to bank 1 (term bit 1); a change of the other bank's terms has no effect on a pin's drive enable.
- R6: The drive value of a pin equals its data input while its drive enable is high and is 0 while it is low.
- R7: The feedback of a pin equals its data input while it drives and equals its pad input while it does not.
- R8: The mode field of pin i sits at bits [2i+1:2i] of the mode vector, and every output follows a change of mode, terms, data or pad input with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oe_mode | input | 24 | Per-pin 2-bit enable mode, pin i at bits [2i+1:2i] |
| term_a | input | 2 | Enable term A, one bit per bank |
| term_b | input | 2 | Enable term B, one bit per bank |
| pin_dout | input | 12 | Data to drive on each pin |
| pad_in | input | 12 | Value driven on each pad from outside |
| pad_oe | output | 12 | Per-pin drive enable |
| pad_out | output | 12 | Per-pin drive value |
| pad_fb | output | 12 | Per-pin pad feedback to the routing |

## Verification
The assertions check, whenever the inputs change, that each pin's drive enable matches what its mode and its own bank's terms call for, and that the feedback comes from the driven data or from the pad input according to that enable. Only the bench's scenarios can show that the pin-to-bank split sits at the right boundary with the other bank's terms toggled while a pin's outputs are watched, that the mode field of each pin sits at its own bit position, and that no output lags its inputs by a cycle.

// File: rtl/io_oe_pkg.sv
package io_oe_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    OE_OFF    = 2'b00,
    OE_ON     = 2'b01,
    OE_TERM_A = 2'b10,
    OE_TERM_B = 2'b11
  } oe_mode_e;
endpackage

// File: rtl/oe_bank_select.sv
module oe_bank_select
  import io_oe_pkg::*;
#(
  parameter int unsigned PINS = 6
) (
  input  logic [PINS*MODE_W-1:0] mode_vec,
  input  logic                   term_a,
  input  logic                   term_b,
  output logic [PINS-1:0]        en
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    oe_mode_e mode_p;
    assign mode_p = oe_mode_e'(mode_vec[p*MODE_W +: MODE_W]);

    always_comb begin
      unique case (mode_p)
        OE_OFF:    en[p] = 1'b0;
        OE_ON:     en[p] = 1'b1;
        OE_TERM_A: en[p] = term_a;
        OE_TERM_B: en[p] = term_b;
        default:   en[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/io_pad_cell.sv
module io_pad_cell (
  input  logic en,
  input  logic dout,
  input  logic pin_in,
  output logic drv_en,
  output logic drv_val,
  output logic fb
);
  always_comb begin
    drv_en  = en;
    drv_val = en & dout;
    fb      = en ? dout : pin_in;
  end
endmodule

// File: rtl/io_bank_oe_ctrl.sv
module io_bank_oe_ctrl
  import io_oe_pkg::*;
#(
  parameter int unsigned BANKS         = 2,
  parameter int unsigned PINS_PER_BANK = 6,
  localparam int unsigned NPIN         = BANKS * PINS_PER_BANK
) (
  input  logic [NPIN*MODE_W-1:0] oe_mode,
  input  logic [BANKS-1:0]       term_a,
  input  logic [BANKS-1:0]       term_b,
  input  logic [NPIN-1:0]        pin_dout,
  input  logic [NPIN-1:0]        pad_in,
  output logic [NPIN-1:0]        pad_oe,
  output logic [NPIN-1:0]        pad_out,
  output logic [NPIN-1:0]        pad_fb
);
  localparam int unsigned BANK_MW = PINS_PER_BANK * MODE_W;

  logic [NPIN-1:0] en_w;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    oe_bank_select #(.PINS(PINS_PER_BANK)) u_sel (
      .mode_vec (oe_mode[b*BANK_MW +: BANK_MW]),
      .term_a   (term_a[b]),
      .term_b   (term_b[b]),
      .en       (en_w[b*PINS_PER_BANK +: PINS_PER_BANK])
    );
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_cell
    io_pad_cell u_cell (
      .en      (en_w[i]),
      .dout    (pin_dout[i]),
      .pin_in  (pad_in[i]),
      .drv_en  (pad_oe[i]),
      .drv_val (pad_out[i]),
      .fb      (pad_fb[i])
    );
  end

  // Cross-check of the bank selectors against the pad cells
  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      if (oe_mode[i*MODE_W +: MODE_W] == OE_OFF)
        p_off_never_drives_r1: assert (!pad_oe[i]);
      if (oe_mode[i*MODE_W +: MODE_W] == OE_ON)
        p_on_always_drives_r2: assert (pad_oe[i]);
      if (oe_mode[i*MODE_W +: MODE_W] == OE_TERM_A)
        p_term_a_own_bank_r3: assert (pad_oe[i] == term_a[i / PINS_PER_BANK]);
      if (oe_mode[i*MODE_W +: MODE_W] == OE_TERM_B)
        p_term_b_own_bank_r4: assert (pad_oe[i] == term_b[i / PINS_PER_BANK]);
      if (!pad_oe[i])
        p_idle_value_zero_r6: assert (!pad_out[i]);
      if (pad_oe[i])
        p_fb_from_driver_r7: assert (pad_fb[i] == pad_out[i]);
      else
        p_fb_from_pad_r7: assert (pad_fb[i] == pad_in[i]);
    end
  end
endmodule

// File: tb/sim_io_bank_oe_ctrl.sv
module sim_io_bank_oe_ctrl;
  localparam int NP = 12;
  localparam int PPB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2*NP-1:0] oe_mode;
  logic [1:0]      term_a, term_b;
  logic [NP-1:0]   pin_dout, pad_in;
  logic [NP-1:0]   pad_oe, pad_out, pad_fb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  io_bank_oe_ctrl u0 (
    .oe_mode(oe_mode), .term_a(term_a), .term_b(term_b),
    .pin_dout(pin_dout), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_fb(pad_fb)
  );

  // Behavioural reference: per-pin expected values from the requirements
  function automatic bit exp_en(int i);
    int m = oe_mode[2*i +: 2];
    int bk = (i < PPB) ? 0 : 1;
    case (m)
      0: return 1'b0;
      1: return 1'b1;
      2: return term_a[bk];
      default: return term_b[bk];
    endcase
  endfunction

  function automatic string tag(int i);
    case (int'(oe_mode[2*i +: 2]))
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int pin, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s pin %0d %s: actual %0d expected %0d", req, pin, what, act, exp);
    end
  endtask

  // Compare every pin on the falling edge (R8: same-cycle response)
  task automatic compare_all(string ctx);
    for (int i = 0; i < NP; i++) begin
      bit e = exp_en(i);
      chk(pad_oe[i] == e, tag(i), i, {ctx, " oe"}, pad_oe[i], e);
      chk(pad_out[i] == (e & pin_dout[i]), "R6", i, {ctx, " out"}, pad_out[i], e & pin_dout[i]);
      chk(pad_fb[i] == (e ? pin_dout[i] : pad_in[i]), "R7", i, {ctx, " fb"},
          pad_fb[i], e ? pin_dout[i] : pad_in[i]);
    end
  endtask

  task automatic step(string ctx);
    @(negedge clk);
    compare_all(ctx);
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2*NP-1:0] all_mode(logic [1:0] m);
    logic [2*NP-1:0] v;
    for (int i = 0; i < NP; i++) v[2*i +: 2] = m;
    return v;
  endfunction

  initial begin
    oe_mode = '0; term_a = 2'b11; term_b = 2'b11;
    pin_dout = 12'hFFF; pad_in = 12'h5A5;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    step("R1 default all off");

    oe_mode = all_mode(2'b01); term_a = 0; term_b = 0; pin_dout = 12'hA3C;
    step("R2 all on");

    oe_mode = all_mode(2'b10);
    for (int t = 0; t < 4; t++) begin
      term_a = t[1:0]; term_b = ~t[1:0];
      step("R3 term A sweep");
    end
    oe_mode = all_mode(2'b11);
    for (int t = 0; t < 4; t++) begin
      term_b = t[1:0]; term_a = ~t[1:0];
      step("R4 term B sweep");
    end

    // R5: bank 0 pins on A, bank 1 pins off; toggle bank 1 terms only
    oe_mode = '0;
    for (int i = 0; i < PPB; i++) oe_mode[2*i +: 2] = 2'b10;
    term_a = 2'b01; term_b = 2'b00;
    step("R5 bank0 base");
    term_a = 2'b11; term_b = 2'b10;
    step("R5 bank1 toggled");
    chk(pad_oe[PPB-1:0] == 6'h3F, "R5", PPB-1, "bank0 oe under bank1 change", pad_oe[PPB-1:0], 6'h3F);
    chk(pad_oe[NP-1:PPB] == 6'h00, "R5", PPB, "bank1 pins off", pad_oe[NP-1:PPB], 0);
    // boundary pins 5 and 6 on term B of opposite banks
    oe_mode = '0; oe_mode[2*5 +: 2] = 2'b11; oe_mode[2*6 +: 2] = 2'b11;
    term_b = 2'b01;
    step("R5 boundary");
    chk(pad_oe[5] && !pad_oe[6], "R5", 5, "boundary 5/6", {pad_oe[6], pad_oe[5]}, 1);

    // R8: each pin alone enabled, others off: field position
    for (int i = 0; i < NP; i++) begin
      oe_mode = '0; oe_mode[2*i +: 2] = 2'b01;
      step("R8 field position");
      chk(pad_oe == (12'b1 << i), "R8", i, "one-hot oe", pad_oe, 12'b1 << i);
    end

    // R7 bidirectional: pad input changes while disabled and enabled
    oe_mode = all_mode(2'b10); term_a = 2'b01;
    for (int k = 0; k < 4; k++) begin
      pad_in = 12'(k * 12'h6B3); pin_dout = 12'(~(k * 12'h3C5));
      step("R7 bidir");
    end

    // Mixed random patterns
    for (int k = 0; k < 200; k++) begin
      oe_mode = {$urandom, $urandom} >> 8;
      term_a = 2'($urandom); term_b = 2'($urandom);
      pin_dout = 12'($urandom); pad_in = 12'($urandom);
      step("R8 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule